// File: doc/BRIEF.md
# Asynchronous Flash Bus Cycle Interface

This block sits between an external asynchronous byte-wide flash-style bus and the synchronous logic of a memory model or controller. The host drives active-low chip, output and write enables, an active-low device reset, an 18-bit address and an 8-bit data byte with no clock of its own. The block samples every pin on the system clock through two flops. It then works out from those samples whether the host is reading or writing.

For reads it presents the sampled address to the array side. It returns the array's byte together with an explicit drive enable, which a pad ring uses to switch the data pins between driving and high impedance. For writes it accepts cycles timed by either the write enable or the chip enable. The address comes from the moment the second of the two enables goes low. The data comes from the last sample taken before the first of the two enables returns high. Each accepted write is handed to a downstream command decoder as a single-cycle strobe carrying that address and data.

Top module: `flash_bus_frontend`

## Requirements
- R1: `bus_dout_en` is 1 after a rising clock edge exactly when the bus pins sampled two edges earlier showed chip enable low, output enable low, write enable high and device reset high; otherwise it is 0.
- R2: `bus_dout` equals the `rd_data` value present at the same clock edge whenever `bus_dout_en` is 1, and is all zeros when `bus_dout_en` is 0; `rd_addr` equals the bus address sampled one edge earlier.
- R3: A write-enable-timed cycle, in which chip enable is low first and write enable then pulses low with output enable high, produces exactly one strobe.
- R4: A chip-enable-timed cycle, in which write enable is low first and chip enable then pulses low with output enable high, produces exactly one strobe, as does a cycle where both enables fall in the same sample.
- R5: `wr_addr` carries the address sampled when chip enable and write enable were first both seen low.
- R6: `wr_data` carries the data sampled in the last sample where both enables were low, before either returned high.
- R7: No strobe is produced if output enable is low when both enables are first seen low, or if output enable goes low at any point before the write ends.
- R8: While the device reset pin is sampled low, `bus_dout_en` is 0, no write is accepted, and a write already in progress is discarded.
- R9: `wr_stb` is high for exactly one clock per accepted write; it goes high on the edge after the first sample showing an enable high, and `wr_addr`/`wr_data` hold their values until the next strobe.
- R10: While system reset `rst_n` is low, `bus_dout_en`, `bus_dout`, `wr_stb`, `wr_addr` and `wr_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| bus_ce_n | input | 1 | Bus chip enable, active low, asynchronous |
| bus_oe_n | input | 1 | Bus output enable, active low, asynchronous |
| bus_we_n | input | 1 | Bus write enable, active low, asynchronous |
| bus_rst_n | input | 1 | Bus device reset, active low, asynchronous |
| bus_addr | input | 18 | Bus address pins |
| bus_din | input | 8 | Data pins as seen when the host drives them |
| rd_data | input | 8 | Byte returned by the array for `rd_addr` |
| rd_addr | output | 18 | Sampled bus address for the array read |
| bus_dout | output | 8 | Byte to drive onto the data pins |
| bus_dout_en | output | 1 | Drive enable for the data pins; 0 means high impedance |
| wr_stb | output | 1 | One-cycle write strobe to the command decoder |
| wr_addr | output | 18 | Captured write address |
| wr_data | output | 8 | Captured write data |

## Verification
Writes are applied in three timings: chip enable leading, write enable leading, and both falling together. The address and data are changed while the enables are low, which shows whether capture uses the later falling edge and the earlier rising edge rather than any other sample. Output enable held low from the start and output enable dropped midway are run separately, so that gating on entry is told apart from an abort during the write. The device reset pin is pulsed during both a read and an open write. A long stretch of random pin activity is then compared on every clock against the behavioural model, which reaches orderings that the directed cases do not.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;

  // Synchronized view of the asynchronous bus control pins (all active low).
  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic rst_n;
  } fe_ctrl_t;

  localparam int unsigned CTRL_W = $bits(fe_ctrl_t);

  typedef enum logic {
    WS_IDLE  = 1'b0,
    WS_ARMED = 1'b1
  } fe_wstate_e;

endpackage

// File: rtl/flash_fe_sync.sv
module flash_fe_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb stg_d[0] = d;
    end else begin : g_chain
      always_comb stg_d = {stg_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= {STAGES{RST_VAL}};
    end else begin
      stg_q <= stg_d;
    end
  end

  assign q = stg_q[LAST];

endmodule

// File: rtl/flash_fe_read.sv
module flash_fe_read
  import flash_fe_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fe_ctrl_t          ctrl,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_dout_en
);

  logic              en_d;
  logic              en_q;
  logic [DATA_W-1:0] dout_d;
  logic [DATA_W-1:0] dout_q;

  always_comb begin
    en_d   = !ctrl.ce_n && !ctrl.oe_n && ctrl.we_n && ctrl.rst_n;
    dout_d = en_d ? rd_data : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      dout_q <= '0;
    end else begin
      en_q   <= en_d;
      dout_q <= dout_d;
    end
  end

  assign bus_dout    = dout_q;
  assign bus_dout_en = en_q;

  // R2
  released_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_dout_en |-> (bus_dout == '0));

  // R1
  drive_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_dout_en) |-> $past(!ctrl.ce_n && !ctrl.oe_n && ctrl.we_n));

  // R8
  reset_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.rst_n |=> !bus_dout_en);

endmodule

// File: rtl/flash_fe_write.sv
module flash_fe_write
  import flash_fe_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fe_ctrl_t          ctrl,
  input  logic [ADDR_W-1:0] addr_s,
  input  logic [DATA_W-1:0] data_s,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);

  fe_wstate_e        state_q, state_d;
  logic              both_q, both_d;
  logic [ADDR_W-1:0] cap_addr_q, cap_addr_d;
  logic [DATA_W-1:0] cap_data_q, cap_data_d;
  logic              stb_q, stb_d;
  logic [ADDR_W-1:0] out_addr_q, out_addr_d;
  logic [DATA_W-1:0] out_data_q, out_data_d;

  logic both_low;
  logic cycle_ok;
  logic enter;

  always_comb begin
    both_low = !ctrl.ce_n && !ctrl.we_n;
    cycle_ok = ctrl.oe_n && ctrl.rst_n;
    enter    = both_low && !both_q && cycle_ok;

    state_d    = state_q;
    both_d     = both_low;
    cap_addr_d = cap_addr_q;
    cap_data_d = cap_data_q;
    stb_d      = 1'b0;
    out_addr_d = out_addr_q;
    out_data_d = out_data_q;

    unique case (state_q)
      WS_IDLE: begin
        if (enter) begin
          state_d    = WS_ARMED;
          cap_addr_d = addr_s;
          cap_data_d = data_s;
        end
      end
      WS_ARMED: begin
        if (!cycle_ok) begin
          state_d = WS_IDLE;
        end else if (!both_low) begin
          state_d    = WS_IDLE;
          stb_d      = 1'b1;
          out_addr_d = cap_addr_q;
          out_data_d = cap_data_q;
        end else begin
          cap_data_d = data_s;
        end
      end
      default: state_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= WS_IDLE;
      both_q     <= 1'b0;
      cap_addr_q <= '0;
      cap_data_q <= '0;
      stb_q      <= 1'b0;
      out_addr_q <= '0;
      out_data_q <= '0;
    end else begin
      state_q    <= state_d;
      both_q     <= both_d;
      cap_addr_q <= cap_addr_d;
      cap_data_q <= cap_data_d;
      stb_q      <= stb_d;
      if (stb_d) begin
        out_addr_q <= out_addr_d;
        out_data_q <= out_data_d;
      end
    end
  end

  assign wr_stb  = stb_q;
  assign wr_addr = out_addr_q;
  assign wr_data = out_data_q;

  // R9
  stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  // R9
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |-> $stable(wr_addr) && $stable(wr_data));

  // R7
  oe_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.oe_n |=> !wr_stb);

  // R8
  rst_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.rst_n |=> !wr_stb);

  // R5
  armed_before_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(state_q == WS_ARMED));

endmodule

// File: rtl/flash_bus_frontend.sv
module flash_bus_frontend
  import flash_fe_pkg::*;
#(
  parameter int unsigned ADDR_W      = 18,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_ce_n,
  input  logic              bus_oe_n,
  input  logic              bus_we_n,
  input  logic              bus_rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_din,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_dout_en,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);

  localparam int unsigned AD_W = ADDR_W + DATA_W;

  // Reset: asserted asynchronously, released on the clock.
  logic rst_sync_n;

  flash_fe_sync #(
    .W       (1),
    .STAGES  (2),
    .RST_VAL (1'b0)
  ) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_sync_n)
  );

  // Control pins: synchronized, idle (all high) out of reset.
  fe_ctrl_t              ctrl_raw;
  fe_ctrl_t              ctrl_s;
  logic [CTRL_W-1:0]     ctrl_s_bits;

  always_comb begin
    ctrl_raw.ce_n  = bus_ce_n;
    ctrl_raw.oe_n  = bus_oe_n;
    ctrl_raw.we_n  = bus_we_n;
    ctrl_raw.rst_n = bus_rst_n;
  end

  flash_fe_sync #(
    .W       (CTRL_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL ({CTRL_W{1'b1}})
  ) u_ctrl_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (ctrl_raw),
    .q     (ctrl_s_bits)
  );

  assign ctrl_s = fe_ctrl_t'(ctrl_s_bits);

  // Address and data pins: delayed by the same depth so they line up.
  logic [AD_W-1:0] ad_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] data_s;

  flash_fe_sync #(
    .W       (AD_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL ({AD_W{1'b0}})
  ) u_ad_align (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     ({bus_addr, bus_din}),
    .q     (ad_s)
  );

  assign addr_s  = ad_s[AD_W-1:DATA_W];
  assign data_s  = ad_s[DATA_W-1:0];
  assign rd_addr = addr_s;

  flash_fe_read #(
    .DATA_W (DATA_W)
  ) u_read (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .ctrl        (ctrl_s),
    .rd_data     (rd_data),
    .bus_dout    (bus_dout),
    .bus_dout_en (bus_dout_en)
  );

  flash_fe_write #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_write (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .ctrl    (ctrl_s),
    .addr_s  (addr_s),
    .data_s  (data_s),
    .wr_stb  (wr_stb),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
  );

  // R10
  sys_reset_quiet_chk: assert property (@(posedge clk)
    !rst_sync_n |-> !bus_dout_en && !wr_stb && (wr_addr == '0) && (wr_data == '0));

  // R7
  no_drive_during_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_stb |-> !bus_dout_en);

endmodule

// File: tb/sim_flash_bus_frontend.sv
`timescale 1ns/1ps
module sim_flash_bus_frontend;

  localparam int AW = 18;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ce_n, oe_n, we_n, brst_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] din;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] bus_dout;
  logic          bus_dout_en;
  logic          wr_stb;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  always #2 clk = ~clk;

  flash_bus_frontend u0 (
    .clk(clk), .rst_n(rst_n),
    .bus_ce_n(ce_n), .bus_oe_n(oe_n), .bus_we_n(we_n), .bus_rst_n(brst_n),
    .bus_addr(addr), .bus_din(din), .rd_data(rd_data),
    .rd_addr(rd_addr), .bus_dout(bus_dout), .bus_dout_en(bus_dout_en),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  int stb_cnt = 0;

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  typedef struct packed {
    logic ce, oe, we, rs;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
  } pins_t;

  localparam pins_t IDLE = '{ce:1'b1, oe:1'b1, we:1'b1, rs:1'b1, a:'0, d:'0};

  pins_t         hist[$];
  bit            m_armed, m_both_prev;
  logic [AW-1:0] m_cap_a;
  logic [DW-1:0] m_cap_d;
  logic          m_en, m_stb;
  logic [DW-1:0] m_dout;
  logic [AW-1:0] m_waddr, m_raddr;
  logic [DW-1:0] m_wdata;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist.delete();
      hist.push_back(IDLE);
      hist.push_back(IDLE);
      m_armed = 0; m_both_prev = 0;
      m_cap_a = '0; m_cap_d = '0;
      m_en = 0; m_stb = 0; m_dout = '0;
      m_waddr = '0; m_wdata = '0; m_raddr = '0;
    end else begin
      pins_t v;
      bit both;
      hist.push_back('{ce:ce_n, oe:oe_n, we:we_n, rs:brst_n, a:addr, d:din});
      v       = hist[0];
      m_raddr = hist[1].a;
      m_en    = !v.ce && !v.oe && v.we && v.rs;
      m_dout  = m_en ? rd_data : '0;
      both    = !v.ce && !v.we;
      m_stb   = 0;
      if (m_armed) begin
        if (!v.rs || !v.oe) m_armed = 0;
        else if (!both) begin
          m_armed = 0; m_stb = 1; m_waddr = m_cap_a; m_wdata = m_cap_d;
        end else m_cap_d = v.d;
      end else if (both && !m_both_prev && v.oe && v.rs) begin
        m_armed = 1; m_cap_a = v.a; m_cap_d = v.d;
      end
      m_both_prev = both;
      void'(hist.pop_front());
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      check("R1", "bus_dout_en", bus_dout_en, m_en);
      check("R2", "bus_dout", bus_dout, m_dout);
      check("R2", "rd_addr", rd_addr, m_raddr);
      check("R9", "wr_stb", wr_stb, m_stb);
      check("R5", "wr_addr", wr_addr, m_waddr);
      check("R6", "wr_data", wr_data, m_wdata);
      if (wr_stb) stb_cnt++;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle_bus();
    ce_n = 1; oe_n = 1; we_n = 1; brst_n = 1; addr = '0; din = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int s;
    idle_bus();
    rd_data = 8'h00;
    rst_n = 0;
    step(3);
    // R10: quiet during system reset
    check("R10", "dout_en in reset", bus_dout_en, 0);
    check("R10", "stb in reset", wr_stb, 0);
    check("R10", "wr_addr in reset", wr_addr, 0);
    check("R10", "wr_data in reset", wr_data, 0);
    rst_n = 1;
    step(6);

    // R1/R2: plain read
    addr = 18'h1234; rd_data = 8'h5A; ce_n = 0; oe_n = 0;
    step(5);
    check("R1", "read drive", bus_dout_en, 1);
    check("R2", "read byte", bus_dout, 8'h5A);
    check("R2", "read addr", rd_addr, 18'h1234);
    // R8: bus reset during read releases the pins
    brst_n = 0; step(5);
    check("R8", "reset read release", bus_dout_en, 0);
    brst_n = 1; oe_n = 1; ce_n = 1; step(4);
    check("R1", "released after read", bus_dout_en, 0);

    // R3/R5/R6: write-enable timed, address moves between the falls
    s = stb_cnt;
    ce_n = 0; addr = 18'h00AAA; din = 8'h11; step(3);
    addr = 18'h2BEEF; we_n = 0; din = 8'h22; step(3);
    din = 8'h33; step(3);
    we_n = 1; step(1);
    din = 8'hEE; addr = 18'h3FFFF; ce_n = 1; step(6);
    check("R3", "we-timed strobes", stb_cnt - s, 1);
    check("R5", "we-timed addr", wr_addr, 18'h2BEEF);
    check("R6", "we-timed data", wr_data, 8'h33);

    // R4: chip-enable timed
    s = stb_cnt;
    we_n = 0; addr = 18'h01111; din = 8'h44; step(3);
    addr = 18'h15555; ce_n = 0; step(2);
    din = 8'h66; step(2);
    ce_n = 1; step(1);
    din = 8'h99; we_n = 1; step(6);
    check("R4", "ce-timed strobes", stb_cnt - s, 1);
    check("R5", "ce-timed addr", wr_addr, 18'h15555);
    check("R6", "ce-timed data", wr_data, 8'h66);

    // R4: simultaneous fall and rise
    s = stb_cnt;
    addr = 18'h0C0DE; din = 8'h77; ce_n = 0; we_n = 0; step(3);
    ce_n = 1; we_n = 1; din = 8'h00; step(6);
    check("R4", "simultaneous strobes", stb_cnt - s, 1);
    check("R5", "simultaneous addr", wr_addr, 18'h0C0DE);
    check("R6", "simultaneous data", wr_data, 8'h77);

    // R7: output enable low from the start
    s = stb_cnt;
    oe_n = 0; step(2);
    addr = 18'h00001; din = 8'h01; ce_n = 0; we_n = 0; step(4);
    we_n = 1; step(1); ce_n = 1; step(2); oe_n = 1; step(6);
    check("R7", "oe low at entry", stb_cnt - s, 0);
    check("R9", "addr held", wr_addr, 18'h0C0DE);

    // R7: output enable dropped mid-write
    s = stb_cnt;
    addr = 18'h00002; ce_n = 0; we_n = 0; step(4);
    oe_n = 0; step(3); oe_n = 1; step(2);
    we_n = 1; ce_n = 1; step(6);
    check("R7", "oe drop mid-write", stb_cnt - s, 0);

    // R8: device reset pulsed mid-write
    s = stb_cnt;
    addr = 18'h00003; ce_n = 0; we_n = 0; step(4);
    brst_n = 0; step(3); brst_n = 1; step(3);
    we_n = 1; ce_n = 1; step(6);
    check("R8", "reset mid-write", stb_cnt - s, 0);
    check("R6", "data held", wr_data, 8'h77);

    // Random activity, checked every clock against the model
    for (int i = 0; i < 6000; i++) begin
      int r;
      r = $urandom_range(0, 15);
      if (r == 0) ce_n = ~ce_n;
      if (r == 1) we_n = ~we_n;
      if (r == 2) oe_n = ($urandom_range(0, 3) == 0) ? 1'b0 : 1'b1;
      if (r == 3) brst_n = ($urandom_range(0, 7) == 0) ? 1'b0 : 1'b1;
      if (r >= 4 && r < 8) addr = AW'($urandom);
      if (r >= 8 && r < 12) din = DW'($urandom);
      rd_data = DW'($urandom);
      step(1);
    end
    idle_bus();
    step(8);
    check("R9", "strobes seen in run", (stb_cnt > 3) ? 1 : 0, 1);
    finish_run();
  end

endmodule